// File: doc/BRIEF.md
# Table-Driven Register Write Sequencer

After reset this block reads a fixed table of start-up commands, one entry at a time, from entry 0 upward. It turns each entry into a single write on a simple strobe/acknowledge register bus. Every 48-bit entry carries a 16-bit register address and a 32-bit write value. The top four bits of the address pick the target peripheral, and the other twelve bits give the register offset inside it. An all-ones entry ends the walk early. If there is none, the walk ends after the last entry. The block then raises a sticky done flag and stays quiet until the next reset.

The table is a parameter that is fixed at elaboration. A system uses the block to bring peripherals into a known state in a fixed order, for example setting a clock divider and a device select before it triggers a serial transfer. Later writes depend on earlier ones, so the order of the writes is part of the function.

Top module: `rom_write_seq`

## Requirements
- R1: Entry bits [31:0] appear on `bus_data_o`, and entry bits [43:32] (the lower 12 bits of the address half, bits [47:32]) appear on `bus_addr_o`.
- R2: Entry bits [47:44] select the peripheral. A value k below N_SLAVES drives `bus_sel_o` one-hot with only bit k set. `bus_sel_o` is all zero whenever `bus_stb_o` is low.
- R3: An entry whose select value has no peripheral raises `bus_stb_o` with `bus_sel_o` all zero for exactly one cycle. The block completes that write by itself and does not wait for any acknowledge.
- R4: Entries are issued in strictly ascending index order starting at entry 0, one bus write per entry. Two entries that address the same register (for example 0x3418 and then 0x3518) give two separate writes in that order.
- R5: An entry equal to 48'hFFFF_FFFF_FFFF issues no write. Entries after it are never issued. `done_o` rises on the second clock edge after the previous write completes.
- R6: With no terminator in the table, the walk stops after the entry at index N_ENTRIES-1. `done_o` rises on the same edge that completes that entry's write, and no entry is issued twice.
- R7: While `bus_stb_o` is high and the write is not yet accepted, `bus_sel_o`, `bus_addr_o` and `bus_data_o` hold their values. A write is accepted only on a cycle where some `bus_ack_i` bit matches a set `bus_sel_o` bit. An acknowledge from a peripheral that is not selected is ignored. The strobe drops on the edge after acceptance.
- R8: Once high, `done_o` stays high until reset, and `bus_stb_o` stays low while `done_o` is high.
- R9: Driving `rst_ni` low at once clears `bus_stb_o`, `bus_sel_o` and `done_o`, even in the middle of a write. After release, the walk restarts at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_ack_i | input | N_SLAVES | Per-peripheral write acknowledge |
| bus_stb_o | output | 1 | Write strobe, held until accepted |
| bus_sel_o | output | N_SLAVES | One-hot peripheral select |
| bus_addr_o | output | ADDR_W-SEL_W | Register offset inside the peripheral |
| bus_data_o | output | DATA_W | Write value |
| done_o | output | 1 | Sticky sequence-complete flag |

## Verification
The hardest case to reach from the ports is a strobe that stays outstanding while a wrong acknowledge is present. Here the select, offset and data must hold even though some `bus_ack_i` bit is toggling. The bench's peripheral model answers one chosen write with the inverse of the select mask for several cycles before it gives the right acknowledge. The same test table also contains an entry with an unmapped select, an entry whose data is all ones but which is not a terminator, and live entries placed after the terminator. A reset is applied while that stalled write is pending, which checks both that the outputs clear at once and that the walk restarts from entry 0. A second instance runs a table with no terminator that ends in a near-all-ones entry, to exercise the end-of-table stop.

// File: rtl/rws_pkg.sv
package rws_pkg;

  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_ENTRY_W = 48;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } rws_state_e;

  // Example bring-up: board control, then divider, select and a triggered transfer.
  function automatic logic [DEF_ENTRIES*DEF_ENTRY_W-1:0] default_table();
    logic [DEF_ENTRIES*DEF_ENTRY_W-1:0] t;
    t = '1;
    t[0*DEF_ENTRY_W +: DEF_ENTRY_W] = 48'h0010_0000_00C3;
    t[1*DEF_ENTRY_W +: DEF_ENTRY_W] = 48'h1004_0000_0002;
    t[2*DEF_ENTRY_W +: DEF_ENTRY_W] = 48'h1008_0000_0001;
    t[3*DEF_ENTRY_W +: DEF_ENTRY_W] = 48'h1000_0000_3418;
    t[4*DEF_ENTRY_W +: DEF_ENTRY_W] = 48'h100C_0000_0010;
    t[5*DEF_ENTRY_W +: DEF_ENTRY_W] = 48'h1000_0000_3518;
    return t;
  endfunction

endpackage

// File: rtl/rws_table.sv
module rws_table #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned IDX_W     = 4,
  parameter logic [N_ENTRIES*(ADDR_W+DATA_W)-1:0] TABLE = '1
) (
  input  logic [IDX_W-1:0]        idx_i,
  output logic [SEL_W-1:0]        sel_field_o,
  output logic [ADDR_W-SEL_W-1:0] offs_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    term_o
);
  localparam int unsigned ENTRY_W = ADDR_W + DATA_W;
  localparam int unsigned OFFS_W  = ADDR_W - SEL_W;

  logic [ENTRY_W-1:0] rom [N_ENTRIES];
  logic [ENTRY_W-1:0] entry;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_rom
    assign rom[g] = TABLE[g*ENTRY_W +: ENTRY_W];
  end

  assign entry       = rom[idx_i];
  assign data_o      = entry[DATA_W-1:0];
  assign offs_o      = entry[DATA_W +: OFFS_W];
  assign sel_field_o = entry[ENTRY_W-1 -: SEL_W];
  assign term_o      = &entry;

endmodule

// File: rtl/rws_decode.sv
module rws_decode #(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned N_SLAVES = 4
) (
  input  logic [SEL_W-1:0]    field_i,
  output logic [N_SLAVES-1:0] onehot_o
);
  for (genvar g = 0; g < N_SLAVES; g++) begin : g_sel
    assign onehot_o[g] = (field_i == SEL_W'(g));
  end
endmodule

// File: rtl/rws_ctrl.sv
module rws_ctrl
  import rws_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned N_SLAVES  = 4,
  parameter int unsigned OFFS_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                term_i,
  input  logic [N_SLAVES-1:0] sel_hot_i,
  input  logic [OFFS_W-1:0]   offs_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [N_SLAVES-1:0] ack_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic                stb_o,
  output logic [N_SLAVES-1:0] sel_o,
  output logic [OFFS_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  rws_state_e          state_q;
  logic [IDX_W-1:0]    idx_q;
  logic                stb_q;
  logic [N_SLAVES-1:0] sel_q;
  logic [OFFS_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic                xfer_done;

  // Unmapped select completes without waiting on any peripheral.
  assign xfer_done = stb_q && ((|(ack_i & sel_q)) || (sel_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      idx_q   <= '0;
      stb_q   <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_LOAD: begin
          if (term_i) begin
            state_q <= ST_DONE;
          end else begin
            stb_q   <= 1'b1;
            sel_q   <= sel_hot_i;
            addr_q  <= offs_i;
            data_q  <= data_i;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (xfer_done) begin
            stb_q <= 1'b0;
            sel_q <= '0;
            if (idx_q == LAST_IDX) begin
              state_q <= ST_DONE;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= ST_LOAD;
            end
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign stb_o  = stb_q;
  assign sel_o  = sel_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/rom_write_seq.sv
module rom_write_seq #(
  parameter int unsigned N_ENTRIES = rws_pkg::DEF_ENTRIES,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned N_SLAVES  = 4,
  parameter logic [N_ENTRIES*(ADDR_W+DATA_W)-1:0] TABLE = rws_pkg::default_table()
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_SLAVES-1:0]        bus_ack_i,
  output logic                       bus_stb_o,
  output logic [N_SLAVES-1:0]        bus_sel_o,
  output logic [ADDR_W-SEL_W-1:0]    bus_addr_o,
  output logic [DATA_W-1:0]          bus_data_o,
  output logic                       done_o
);
  localparam int unsigned OFFS_W = ADDR_W - SEL_W;
  localparam int unsigned IDX_W  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [IDX_W-1:0]    idx;
  logic [SEL_W-1:0]    sel_field;
  logic [OFFS_W-1:0]   offs;
  logic [DATA_W-1:0]   data;
  logic                term;
  logic [N_SLAVES-1:0] sel_hot;

  rws_table #(
    .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SEL_W(SEL_W), .IDX_W(IDX_W), .TABLE(TABLE)
  ) u_table (
    .idx_i      (idx),
    .sel_field_o(sel_field),
    .offs_o     (offs),
    .data_o     (data),
    .term_o     (term)
  );

  rws_decode #(.SEL_W(SEL_W), .N_SLAVES(N_SLAVES)) u_decode (
    .field_i (sel_field),
    .onehot_o(sel_hot)
  );

  rws_ctrl #(
    .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .N_SLAVES(N_SLAVES),
    .OFFS_W(OFFS_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .term_i   (term),
    .sel_hot_i(sel_hot),
    .offs_i   (offs),
    .data_i   (data),
    .ack_i    (bus_ack_i),
    .idx_o    (idx),
    .stb_o    (bus_stb_o),
    .sel_o    (bus_sel_o),
    .addr_o   (bus_addr_o),
    .data_o   (bus_data_o),
    .done_o   (done_o)
  );

endmodule

// File: rtl/rws_chk.sv
module rws_chk #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned N_SLAVES  = 4,
  parameter int unsigned OFFS_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_SLAVES-1:0] ack_i,
  input logic                stb_i,
  input logic [N_SLAVES-1:0] sel_i,
  input logic [OFFS_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   data_i,
  input logic                done_i
);
  localparam int unsigned CNT_W = $clog2(N_ENTRIES + 2);

  logic             xfer;
  logic [CNT_W-1:0] n_xfer_q;

  assign xfer = stb_i && ((|(ack_i & sel_i)) || (sel_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   n_xfer_q <= '0;
    else if (xfer) n_xfer_q <= n_xfer_q + CNT_W'(1);
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !xfer |=> stb_i && $stable(sel_i) && $stable(addr_i) && $stable(data_i));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> !stb_i);

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |-> $onehot0(sel_i));

  p_idle_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |-> (sel_i == '0));

  p_unmapped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && (sel_i == '0) |=> !stb_i);

  p_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !stb_i);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i);

  p_budget_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_xfer_q <= CNT_W'(N_ENTRIES));

endmodule

bind rom_write_seq rws_chk #(
  .N_ENTRIES(N_ENTRIES), .N_SLAVES(N_SLAVES),
  .OFFS_W(ADDR_W - SEL_W), .DATA_W(DATA_W)
) u_rws_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ack_i (bus_ack_i),
  .stb_i (bus_stb_o),
  .sel_i (bus_sel_o),
  .addr_i(bus_addr_o),
  .data_i(bus_data_o),
  .done_i(done_o)
);

// File: tb/tb_rom_write_seq.sv
`timescale 1ns/1ps
module tb_rom_write_seq;

  localparam int NE = 16;
  localparam int EW = 48;

  typedef struct packed {
    logic [3:0]  sel;
    logic [11:0] offs;
    logic [31:0] data;
  } wr_t;

  function automatic logic [NE*EW-1:0] build_a();
    logic [NE*EW-1:0] t;
    t = '1;
    t[0*EW +: EW]  = 48'h0C00_0000_0F03;
    t[1*EW +: EW]  = 48'h1014_0000_0000;
    t[2*EW +: EW]  = 48'h1018_0000_0001;
    t[3*EW +: EW]  = 48'h1010_0000_3418; // stalled with a wrong ack
    t[4*EW +: EW]  = 48'h1000_0000_0010;
    t[5*EW +: EW]  = 48'h1010_0000_3518; // same register, go bit set
    t[6*EW +: EW]  = 48'h7ABC_1234_5678; // unmapped select
    t[7*EW +: EW]  = 48'h3FFF_DEAD_BEEF;
    t[8*EW +: EW]  = 48'h2001_FFFF_FFFF; // near terminator
    // index 9 stays all ones: terminator
    for (int i = 10; i < NE; i++) t[i*EW +: EW] = {4'h1, 12'(i), 32'hC0DE_0000};
    return t;
  endfunction

  function automatic logic [NE*EW-1:0] build_b();
    logic [NE*EW-1:0] t;
    for (int i = 0; i < NE - 1; i++)
      t[i*EW +: EW] = {4'(i % 4), 12'(i * 37), 32'h5A00_0000 | 32'(i)};
    t[(NE-1)*EW +: EW] = 48'hFFFF_FFFF_FFFE;
    return t;
  endfunction

  localparam logic [NE*EW-1:0] TAB_A = build_a();
  localparam logic [NE*EW-1:0] TAB_B = build_b();

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_a_n, rst_b_n;
  logic [3:0]  ack_a, ack_b;
  logic        stb_a, stb_b, done_a, done_b;
  logic [3:0]  sel_a, sel_b;
  logic [11:0] addr_a, addr_b;
  logic [31:0] data_a, data_b;

  rom_write_seq #(.TABLE(TAB_A)) dut (
    .clk_i(clk), .rst_ni(rst_a_n), .bus_ack_i(ack_a), .bus_stb_o(stb_a),
    .bus_sel_o(sel_a), .bus_addr_o(addr_a), .bus_data_o(data_a), .done_o(done_a));

  rom_write_seq #(.TABLE(TAB_B)) dut_b (
    .clk_i(clk), .rst_ni(rst_b_n), .bus_ack_i(ack_b), .bus_stb_o(stb_b),
    .bus_sel_o(sel_b), .bus_addr_o(addr_b), .bus_data_o(data_b), .done_o(done_b));

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void build_exp(input logic [NE*EW-1:0] tab, ref wr_t q[$]);
    q.delete();
    for (int i = 0; i < NE; i++) begin
      logic [EW-1:0] e;
      wr_t w;
      e = tab[i*EW +: EW];
      if (e == '1) break;
      w.sel  = (e[47:44] < 4) ? (4'b1 << e[47:44]) : 4'b0;
      w.offs = e[43:32];
      w.data = e[31:0];
      q.push_back(w);
    end
  endfunction

  // peripheral models
  int wait_a = 0;
  always begin
    @(negedge clk);
    ack_a = '0;
    if (rst_a_n && stb_a && sel_a != '0) begin
      int lat;
      lat = (got_a.size() == 3) ? 3 : got_a.size() % 3;
      if (wait_a >= lat) begin
        ack_a  = sel_a;
        wait_a = 0;
      end else begin
        if (got_a.size() == 3) ack_a = ~sel_a;
        wait_a++;
      end
    end else begin
      wait_a = 0;
    end
  end

  always begin
    @(negedge clk);
    ack_b = (rst_b_n && stb_b) ? sel_b : '0;
  end

  // monitors: sample away from the active edge
  wr_t got_a[$], got_b[$];
  int  samp = 0;
  int  last_hs_a = 0, done_at_a = 0, last_hs_b = 0, done_at_b = 0;
  bit  seen_a = 0, seen_b = 0, hold_a = 0;
  wr_t held_a;

  always begin
    @(negedge clk); #2;
    samp++;
    if (!rst_a_n) begin
      hold_a = 0; seen_a = 0;
    end else begin
      if (stb_a && hold_a) chk("R7", "held fields", {sel_a, addr_a, data_a}, held_a);
      if (stb_a) begin
        if (((ack_a & sel_a) != '0) || sel_a == '0) begin
          got_a.push_back({sel_a, addr_a, data_a});
          last_hs_a = samp;
          hold_a = 0;
        end else begin
          hold_a = 1;
          held_a = {sel_a, addr_a, data_a};
        end
      end else begin
        hold_a = 0;
      end
      if (done_a && !seen_a) begin seen_a = 1; done_at_a = samp; end
    end
    if (!rst_b_n) begin
      seen_b = 0;
    end else begin
      if (stb_b && (((ack_b & sel_b) != '0) || sel_b == '0)) begin
        got_b.push_back({sel_b, addr_b, data_b});
        last_hs_b = samp;
      end
      if (done_b && !seen_b) begin seen_b = 1; done_at_b = samp; end
    end
  end

  task automatic t_reset_state();
    #1;
    chk("R9", "stb in reset",  stb_a, 0);
    chk("R9", "sel in reset",  sel_a, 0);
    chk("R9", "done in reset", done_a, 0);
    chk("R9", "done b in reset", done_b, 0);
  endtask

  task automatic t_mid_reset();
    wait (got_a.size() == 3);
    repeat (2) @(negedge clk);
    #1;
    chk("R7", "stb while wrong ack", stb_a, 1);
    rst_a_n = 1'b0;
    #1;
    chk("R9", "stb cleared mid write", stb_a, 0);
    chk("R9", "sel cleared mid write", sel_a, 0);
    chk("R9", "done cleared", done_a, 0);
    got_a.delete();
    repeat (2) @(negedge clk);
    #1 rst_a_n = 1'b1;
  endtask

  task automatic t_run_a();
    wr_t exp[$];
    build_exp(TAB_A, exp);
    wait (done_a);
    repeat (2) @(negedge clk);
    chk("R5", "write count", got_a.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got_a.size(); i++) begin
      chk("R4", $sformatf("write %0d order", i), got_a[i], exp[i]);
    end
    if (got_a.size() > 6) begin
      chk("R1", "go-bit data",     got_a[5].data, 32'h3518);
      chk("R2", "slave1 select",   got_a[3].sel,  4'b0010);
      chk("R3", "unmapped select", got_a[6].sel,  4'b0000);
    end
    chk("R5", "done latency after last write", done_at_a - last_hs_a, 2);
  endtask

  task automatic t_done_quiet();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (i % 5 == 0) begin
        chk("R8", "no strobe after done", stb_a, 0);
        chk("R8", "done sticky", done_a, 1);
      end
    end
    chk("R8", "no writes after done", got_a.size(), 9);
  endtask

  task automatic t_run_b();
    wr_t exp[$];
    build_exp(TAB_B, exp);
    wait (done_b);
    repeat (2) @(negedge clk);
    chk("R6", "write count no terminator", got_b.size(), NE);
    for (int i = 0; i < exp.size() && i < got_b.size(); i++) begin
      chk("R6", $sformatf("write %0d", i), got_b[i], exp[i]);
    end
    chk("R6", "done latency at last entry", done_at_b - last_hs_b, 1);
    chk("R8", "no strobe b after done", stb_b, 0);
  endtask

  initial begin
    rst_a_n = 1'b0;
    rst_b_n = 1'b0;
    ack_a   = '0;
    ack_b   = '0;
    t_reset_state();
    repeat (3) @(negedge clk);
    #1;
    rst_a_n = 1'b1;
    rst_b_n = 1'b1;
    t_mid_reset();
    t_run_a();
    t_done_quiet();
    t_run_b();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

endmodule